// File: doc/BRIEF.md
# SMBus Byte Transfer Engine

This block is the master-side bit engine of a two-wire serial bus controller. A host issues one command at a time: START, STOP, WRITE of one byte, or READ of one byte. The engine generates the bus conditions and clocks, and shifts the byte MSB first. It moves the clock line only on pulses from an external bit-rate timer. Both bus lines are open drain: each is a drive-low enable out and a sampled level in, and a slave may stretch any low phase of the clock.

Each transferred byte produces exactly one host event. When the engine transmits, the event follows the acknowledge bit, so the host can read what the slave answered. When it receives with automatic acknowledge enabled, the event also follows the acknowledge bit. When it receives with automatic acknowledge disabled, the event comes before the acknowledge bit. The engine then parks with the clock held low until the host pulses a response carrying the acknowledge value to send. The clock stays low while any event is pending.

Top module: `smb_byte_engine`

## Requirements
- R1: While reset is held, and at release, neither line is driven low, `busy` is 0 and `evtValid` is 0.
- R2: A START command (`cmdOp`=0) leaves SDA high, then releases SCL and waits to see it high. It then pulls SDA low while SCL is high, and finishes with SCL held low. `busy` stays high until the sequence has finished.
- R3: A STOP command (`cmdOp`=1), issued with SCL held low, pulls SDA low, releases SCL, and then releases SDA while SCL is high, which leaves the bus free.
- R4: A WRITE command (`cmdOp`=2) puts `cmdData` on SDA MSB first, one bit per SCL pulse. SDA changes only while SCL is low, so no spurious START or STOP appears during a byte.
- R5: A READ command (`cmdOp`=3) samples SDA on each SCL rising edge and assembles the byte MSB first on `rxData`.
- R6: After a WRITE, the event rises only after the ninth SCL pulse, with `evtPreAck`=0. `rxAck` then holds the SDA level sampled on that ninth rising edge (0 means acknowledged), and `rxData` equals the byte sent.
- R7: A READ with `hwAckEn`=0 at command time raises the event with `evtPreAck`=1 after eight SCL pulses. SCL is held low until an `ackGo` pulse. The `ackBit` given with it is then sent as the ninth bit (0 pulls SDA low, 1 leaves it released). No second event follows for that byte.
- R8: A READ with `hwAckEn`=1 sends an acknowledge (SDA low) on the ninth bit by itself and raises the event after that bit, with `evtPreAck`=0.
- R9: Every SCL high phase starts only when SCL is actually seen high and lasts at least until one timer pulse arrives after that. A slave holding SCL low therefore lengthens the low phase without shortening the high phase.
- R10: `evtValid` stays high with SCL held low until the next accepted command (or `ackGo` in the stall of R7) clears it.
- R11: A `cmdValid` pulse while `busy` is high is ignored: it produces no bus condition and no extra clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle pulse from the bit-rate timer |
| cmdValid | input | 1 | Command pulse, taken when `busy` is 0 |
| cmdOp | input | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmdData | input | DATA_W | Byte to send for WRITE |
| hwAckEn | input | 1 | Automatic acknowledge on receive, latched at command |
| ackGo | input | 1 | Host response pulse during the pre-acknowledge stall |
| ackBit | input | 1 | Acknowledge value to send with `ackGo` (0 = ACK) |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sclDrvLow | output | 1 | Pull SCL low when 1 |
| sdaDrvLow | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Command in progress |
| evtValid | output | 1 | Per-byte event pending |
| evtPreAck | output | 1 | Event is the pre-acknowledge stall of a receive |
| rxData | output | DATA_W | Byte seen on the bus |
| rxAck | output | 1 | SDA level on the last acknowledge clock |

## Verification
Every byte value from 0 to 255 is written and then read back. A bit-order or shift error shows up as a wrong byte for some value. The mode inputs are taken from low bits of the byte, so each byte is paired with a slave ACK or NACK, a hardware or host acknowledge, and a host ACK or NACK. This pairing separates the post-acknowledge event from the stall before the acknowledge, and a sent ACK from a sent NACK. Some bytes also have the slave stretch SCL low after each falling edge, which catches any high phase that is counted before SCL is really seen high. One write carries a stray command pulse mid-byte, which catches a command accepted while busy.

// File: rtl/smb_byte_pkg.sv
`timescale 1ns/1ps
package smb_byte_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } smbOp_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadByte;   // take cmdData into the shifter, clear bit count
    logic sampleBit;  // shift the SDA level in on an SCL rise
    logic sampleAck;  // capture SDA on the acknowledge rise
    logic nextBit;    // advance the bit count
    logic sclLoad;    // update the SCL drive register
    logic sclLow;     // value for it
    logic sdaLoad;    // update the SDA drive register
    logic sdaLow;     // value for it
    logic ackLoad;    // store the host acknowledge value
    logic condPhase;  // inside a START or STOP sequence
  } smbCtl_t;

endpackage

// File: rtl/smb_byte_dpath.sv
`timescale 1ns/1ps
module smb_byte_dpath
  import smb_byte_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  smbCtl_t           ctl,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              sdaIn,
  input  logic              hostAckBit,
  output logic              sclDrvLow,
  output logic              sdaDrvLow,
  output logic              curBit,
  output logic              atAck,
  output logic              ackHeld,
  output logic [DATA_W-1:0] rxData,
  output logic              rxAck
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(DATA_W);

  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bitCnt    <= '0;
      sclDrvLow <= 1'b0;
      sdaDrvLow <= 1'b0;
      ackHeld   <= 1'b0;
      rxAck     <= 1'b1;
    end else begin
      if (ctl.loadByte) begin
        shiftReg <= cmdData;
        bitCnt   <= '0;
      end else begin
        if (ctl.sampleBit) shiftReg <= {shiftReg[DATA_W-2:0], sdaIn};
        if (ctl.nextBit)   bitCnt   <= bitCnt + 1'b1;
      end
      if (ctl.sampleAck) rxAck     <= sdaIn;
      if (ctl.ackLoad)   ackHeld   <= hostAckBit;
      if (ctl.sclLoad)   sclDrvLow <= ctl.sclLow;
      if (ctl.sdaLoad)   sdaDrvLow <= ctl.sdaLow;
    end
  end

  assign curBit = shiftReg[DATA_W-1];
  assign atAck  = (bitCnt == ACK_IDX);
  assign rxData = shiftReg;

  // Data-phase SDA updates only happen with SCL already low and staying low
  AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sdaLoad && !ctl.condPhase) |-> (sclDrvLow && !(ctl.sclLoad && !ctl.sclLow))); // R4

  AST_NO_ADVANCE_PAST_ACK: assert property (@(posedge clk) disable iff (!rstN)
    atAck |-> !ctl.nextBit); // R6

endmodule

// File: rtl/smb_byte_ctrl.sv
`timescale 1ns/1ps
module smb_byte_ctrl
  import smb_byte_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       sclIn,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       hwAckEn,
  input  logic       ackGo,
  input  logic       atAck,
  input  logic       curBit,
  input  logic       ackHeld,
  input  logic       sclHeldLow,
  output smbCtl_t    ctl,
  output logic       busy,
  output logic       evtValid,
  output logic       evtPreAck
);
  typedef enum logic [4:0] {
    S_IDLE, S_ST_REL, S_ST_RISE, S_ST_HIGH, S_ST_SDALOW, S_ST_SCLLOW,
    S_SP_SDALOW, S_SP_RISE, S_SP_HIGH, S_SP_REL,
    S_BIT_LOW, S_BIT_RISE, S_BIT_HIGH, S_BIT_FALL, S_ACK_WAIT,
    S_BYTE_END, S_BYTE_REL
  } state_e;

  state_e state, stateNxt;
  logic   dirRead, hwLat, evtNxt, accept, dataOp;
  smbOp_e op;

  assign op     = smbOp_e'(cmdOp);
  assign accept = (state == S_IDLE) && cmdValid;
  assign dataOp = (op == OP_WRITE) || (op == OP_READ);

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    evtNxt   = accept ? 1'b0 : evtValid;
    case (state)
      S_IDLE: if (cmdValid) begin
        if (op == OP_START)     stateNxt = S_ST_REL;
        else if (op == OP_STOP) stateNxt = S_SP_SDALOW;
        else begin
          ctl.loadByte = 1'b1;
          stateNxt     = S_BIT_LOW;
        end
      end
      S_ST_REL: begin
        ctl.condPhase = 1'b1; ctl.sdaLoad = 1'b1; ctl.sdaLow = 1'b0;
        if (tick) stateNxt = S_ST_RISE;
      end
      S_ST_RISE: begin
        ctl.condPhase = 1'b1; ctl.sclLoad = 1'b1; ctl.sclLow = 1'b0;
        if (sclIn) stateNxt = S_ST_HIGH;
      end
      S_ST_HIGH: begin
        ctl.condPhase = 1'b1;
        if (tick) stateNxt = S_ST_SDALOW;
      end
      S_ST_SDALOW: begin
        ctl.condPhase = 1'b1; ctl.sdaLoad = 1'b1; ctl.sdaLow = 1'b1;
        if (tick) stateNxt = S_ST_SCLLOW;
      end
      S_ST_SCLLOW: begin
        ctl.condPhase = 1'b1; ctl.sclLoad = 1'b1; ctl.sclLow = 1'b1;
        stateNxt = S_IDLE;
      end
      S_SP_SDALOW: begin
        ctl.condPhase = 1'b1; ctl.sdaLoad = 1'b1; ctl.sdaLow = 1'b1;
        if (tick) stateNxt = S_SP_RISE;
      end
      S_SP_RISE: begin
        ctl.condPhase = 1'b1; ctl.sclLoad = 1'b1; ctl.sclLow = 1'b0;
        if (sclIn) stateNxt = S_SP_HIGH;
      end
      S_SP_HIGH: begin
        ctl.condPhase = 1'b1;
        if (tick) stateNxt = S_SP_REL;
      end
      S_SP_REL: begin
        ctl.condPhase = 1'b1; ctl.sdaLoad = 1'b1; ctl.sdaLow = 1'b0;
        stateNxt = S_IDLE;
      end
      S_BIT_LOW: begin
        ctl.sclLoad = 1'b1; ctl.sclLow = 1'b1; ctl.sdaLoad = 1'b1;
        if (atAck) ctl.sdaLow = dirRead && (hwLat || !ackHeld);
        else       ctl.sdaLow = !dirRead && !curBit;
        if (tick) stateNxt = S_BIT_RISE;
      end
      S_BIT_RISE: begin
        ctl.sclLoad = 1'b1; ctl.sclLow = 1'b0;
        if (sclIn) begin
          ctl.sampleBit = !atAck;
          ctl.sampleAck = atAck;
          stateNxt      = S_BIT_HIGH;
        end
      end
      S_BIT_HIGH: if (tick) begin
        if (atAck) stateNxt = S_BYTE_END;
        else begin
          ctl.nextBit = 1'b1;
          stateNxt    = S_BIT_FALL;
        end
      end
      S_BIT_FALL: begin
        ctl.sclLoad = 1'b1; ctl.sclLow = 1'b1;
        if (atAck && dirRead && !hwLat) begin
          stateNxt = S_ACK_WAIT;
          evtNxt   = 1'b1;
        end else stateNxt = S_BIT_LOW;
      end
      S_ACK_WAIT: if (ackGo) begin
        ctl.ackLoad = 1'b1;
        evtNxt      = 1'b0;
        stateNxt    = S_BIT_LOW;
      end
      S_BYTE_END: begin
        ctl.sclLoad = 1'b1; ctl.sclLow = 1'b1;
        stateNxt = S_BYTE_REL;
      end
      S_BYTE_REL: begin
        ctl.sdaLoad = 1'b1; ctl.sdaLow = 1'b0;
        evtNxt   = !(dirRead && !hwLat);
        stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      dirRead  <= 1'b0;
      hwLat    <= 1'b0;
      evtValid <= 1'b0;
    end else begin
      state    <= stateNxt;
      evtValid <= evtNxt;
      if (accept && dataOp) begin
        dirRead <= (op == OP_READ);
        hwLat   <= hwAckEn;
      end
    end
  end

  assign busy      = (state != S_IDLE);
  assign evtPreAck = (state == S_ACK_WAIT);

  AST_STALL_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rstN)
    evtPreAck |-> sclHeldLow); // R7

  AST_RISE_WAITS_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BIT_RISE && !sclIn) |=> (state == S_BIT_RISE)); // R9

  AST_EVT_KEEPS_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> sclHeldLow); // R10

  AST_POST_ACK_EVT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(evtValid) && !evtPreAck) |-> !busy); // R6

  AST_BUSY_CMD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid && state != S_BYTE_REL && state != S_ST_SCLLOW && state != S_SP_REL)
      |=> busy); // R11

endmodule

// File: rtl/smb_byte_engine.sv
`timescale 1ns/1ps
module smb_byte_engine
  import smb_byte_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              hwAckEn,
  input  logic              ackGo,
  input  logic              ackBit,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDrvLow,
  output logic              sdaDrvLow,
  output logic              busy,
  output logic              evtValid,
  output logic              evtPreAck,
  output logic [DATA_W-1:0] rxData,
  output logic              rxAck
);
  smbCtl_t ctl;
  logic    atAck, curBit, ackHeld;

  smb_byte_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .sclIn(sclIn),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .hwAckEn(hwAckEn), .ackGo(ackGo),
    .atAck(atAck), .curBit(curBit), .ackHeld(ackHeld), .sclHeldLow(sclDrvLow),
    .ctl(ctl), .busy(busy), .evtValid(evtValid), .evtPreAck(evtPreAck)
  );

  smb_byte_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdData(cmdData), .sdaIn(sdaIn),
    .hostAckBit(ackBit), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow),
    .curBit(curBit), .atAck(atAck), .ackHeld(ackHeld),
    .rxData(rxData), .rxAck(rxAck)
  );

endmodule

// File: tb/smb_byte_engine_test.sv
`timescale 1ns/1ps
module smb_byte_engine_test;
  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0;
  logic cmdValid = 1'b0, hwAckEn = 1'b0, ackGo = 1'b0, ackBit = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic [7:0] cmdData = 8'd0;
  logic sclDrvLow, sdaDrvLow, busy, evtValid, evtPreAck, rxAck;
  logic [7:0] rxData;
  logic sclBus, sdaBus, slaveSclLow, slaveSdaLow;

  always #4 clk = ~clk; // 125 MHz

  assign sclBus = !(sclDrvLow || slaveSclLow);
  assign sdaBus = !(sdaDrvLow || slaveSdaLow);

  smb_byte_engine #(.DATA_W(8)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .hwAckEn(hwAckEn), .ackGo(ackGo), .ackBit(ackBit),
    .sclIn(sclBus), .sdaIn(sdaBus), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow),
    .busy(busy), .evtValid(evtValid), .evtPreAck(evtPreAck),
    .rxData(rxData), .rxAck(rxAck)
  );

  int total = 0, fails = 0;
  bit finished = 0;

  // bus monitor and slave model
  int riseTot = 0, fallTot = 0, startSeen = 0, stopSeen = 0;
  int shortHigh = 0, ticksHigh = 0, stretchCnt = 0, fallBase = 0, sIdx;
  logic [8:0] capBits = '0;
  logic prevScl = 1'b1, prevSda = 1'b1;
  int sMode = 0;          // 0 silent, 1 acknowledge a write, 2 supply read data
  logic sAckLow = 1'b0, stretchOn = 1'b0;
  logic [7:0] sRd = 8'd0;

  assign sIdx = fallTot - fallBase;
  assign slaveSclLow = (stretchCnt != 0);
  always_comb begin
    slaveSdaLow = 1'b0;
    if (sMode == 1 && sIdx == 8) slaveSdaLow = sAckLow;
    if (sMode == 2 && sIdx >= 0 && sIdx < 8) slaveSdaLow = !sRd[7 - sIdx];
  end

  always @(negedge clk) begin
    if (stretchCnt > 0) stretchCnt = stretchCnt - 1;
    if (tick && prevScl) ticksHigh = ticksHigh + 1;
    if (sclBus && !prevScl) begin
      riseTot = riseTot + 1;
      capBits = {capBits[7:0], sdaBus};
      ticksHigh = 0;
    end
    if (!sclBus && prevScl && rstN) begin
      fallTot = fallTot + 1;
      if (ticksHigh == 0) shortHigh = shortHigh + 1;
      if (stretchOn) stretchCnt = 6;
    end
    if (sclBus && prevScl && sdaBus != prevSda) begin
      if (!sdaBus) startSeen = startSeen + 1;
      else stopSeen = stopSeen + 1;
    end
    prevScl = sclBus;
    prevSda = sdaBus;
  end

  // bit-rate timer: one pulse every four cycles
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      #1 tick = 1'b1;
      @(negedge clk);
      #1 tick = 1'b0;
    end
  end

  task automatic cyc();
    @(negedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doCmd(input logic [1:0] op, input logic [7:0] d);
    while (busy) cyc();
    cmdValid = 1'b1; cmdOp = op; cmdData = d;
    cyc();
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    cyc();
    while (busy) cyc();
    cyc();
  endtask

  task automatic doStart();
    int s0;
    sMode = 0; s0 = startSeen;
    doCmd(2'd0, 8'd0);
    chk("R2 busy during start", busy, 1);
    waitIdle();
    chk("R2 one start condition", startSeen - s0, 1);
    chk("R2 scl held low after start", sclBus, 0);
    chk("R2 sda low after start", sdaBus, 0);
  endtask

  task automatic writeByte(input logic [7:0] b, input logic ackLow, input logic hw,
                           input logic strayCmd);
    int rb, s0, p0;
    sMode = 1; sAckLow = ackLow; stretchOn = (b[2:0] == 3'd5);
    hwAckEn = hw; fallBase = fallTot; rb = riseTot; s0 = startSeen; p0 = stopSeen;
    doCmd(2'd2, b);
    chk("R10 event cleared by command", evtValid, 0);
    if (strayCmd) begin
      repeat (10) cyc();
      cmdValid = 1'b1; cmdOp = 2'd1;
      cyc();
      cmdValid = 1'b0;
    end
    while (!evtValid) cyc();
    cyc();
    stretchOn = 1'b0;
    chk("R6 nine clocks per write", riseTot - rb, 9);
    chk("R4 bits on bus msb first", int'(capBits[8:1]), int'(b));
    chk("R6 rxData equals sent byte", int'(rxData), int'(b));
    chk("R6 rxAck sampled", rxAck, !ackLow);
    chk("R6 event after ack", evtPreAck, 0);
    chk("R4 no condition inside byte", (startSeen - s0) + (stopSeen - p0), 0);
    chk("R9 high phase holds for a tick", shortHigh, 0);
    repeat (5) cyc();
    chk("R10 event held", evtValid, 1);
    chk("R10 scl held low with event", sclBus, 0);
    if (strayCmd) chk("R11 busy command ignored", busy, 0);
  endtask

  task automatic readByte(input logic [7:0] b, input logic hw, input logic ackV);
    int rb, s0, p0;
    sMode = 2; sRd = b; stretchOn = (b[2:0] == 3'd6);
    hwAckEn = hw; fallBase = fallTot; rb = riseTot; s0 = startSeen; p0 = stopSeen;
    doCmd(2'd3, 8'h00);
    while (!evtValid) cyc();
    if (!hw) begin
      chk("R7 stall flagged", evtPreAck, 1);
      chk("R7 eight clocks before stall", riseTot - rb, 8);
      chk("R5 byte assembled", int'(rxData), int'(b));
      chk("R5 bits on bus", int'(capBits[7:0]), int'(b));
      repeat (20) cyc();
      chk("R7 scl held in stall", sclBus, 0);
      chk("R7 no clock during stall", riseTot - rb, 8);
      ackGo = 1'b1; ackBit = ackV;
      cyc();
      ackGo = 1'b0;
      chk("R10 event cleared by response", evtValid, 0);
      waitIdle();
      chk("R7 no second event", evtValid, 0);
      chk("R7 host ack sent", capBits[0], ackV);
      chk("R7 rxAck follows sent bit", rxAck, ackV);
    end else begin
      cyc();
      chk("R8 event after ack", evtPreAck, 0);
      chk("R8 busy low at event", busy, 0);
      chk("R5 byte assembled", int'(rxData), int'(b));
      chk("R8 automatic ack low", capBits[0], 0);
    end
    stretchOn = 1'b0;
    chk("R5 nine clocks per read", riseTot - rb, 9);
    chk("R4 no condition inside byte", (startSeen - s0) + (stopSeen - p0), 0);
    chk("R9 high phase holds for a tick", shortHigh, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (3) cyc();
    chk("R1 scl released in reset", sclDrvLow, 0);
    chk("R1 sda released in reset", sdaDrvLow, 0);
    chk("R1 busy low in reset", busy, 0);
    chk("R1 no event in reset", evtValid, 0);
    rstN = 1'b1;
    cyc();
    chk("R1 idle after reset", {sclDrvLow, sdaDrvLow, busy, evtValid}, 0);
    doStart();
    for (int b = 0; b < 256; b++) begin
      logic [7:0] v;
      v = 8'(b);
      writeByte(v, v[0], v[1], v == 8'h5A);
    end
    doStart();
    for (int b = 0; b < 256; b++) begin
      logic [7:0] v;
      v = 8'(b);
      readByte(v, v[0], v[1]);
    end
    begin
      int p0;
      sMode = 0; p0 = stopSeen;
      doCmd(2'd1, 8'd0);
      waitIdle();
      chk("R3 one stop condition", stopSeen - p0, 1);
      chk("R3 scl free after stop", sclBus, 1);
      chk("R3 sda free after stop", sdaBus, 1);
    end
    summary();
  end

  initial begin
    repeat (195000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

endmodule